// File: doc/BRIEF.md
# Accumulator Pointer Auto-Update Unit

This unit holds the index that picks one of sixteen working accumulators, and a control register that decides how that index moves after each arithmetic or logical operation. Software reaches both registers over a small single-cycle register bus. The datapath pulses `op_done_i` when an ALU operation completes. Depending on the programmed mode, the unit then steps the index up or down. The step can wrap inside an aligned window of 2, 4, 8 or 16 accumulators.

The current index drives the accumulator file directly through `acc_sel_o`. When a software write and an automatic step land in the same cycle, fixed priorities settle the result:

- A clear request beats everything else.
- An enabled step beats a direct pointer write.
- A direct pointer write takes effect only when no step happens.

The accumulator file and the ALU are outside this unit. The unit produces only the select index.

Top module: `acc_ptr_unit`

## Requirements
- R1: Address 0 reads the pointer as {0000, pointer}. Bits 7:4 read 0. A write to address 0 loads the pointer from write bits 3:0 and ignores bits 7:4.
- R2: Address 1 reads the control register. Bit 6 is the direction, bits 2:0 are the mode, and bits 7 and 5:3 always read 0. Writes store bit 6 and bits 2:0 only.
- R3: Any reset (active-low `rst_ni`, asynchronous) sets the pointer and the control register to 00h, and `acc_sel_o` to 0.
- R4: Mode values 000, 101, 110 and 111 disable automatic change. In these modes `op_done_i` leaves the pointer untouched, whatever the direction bit holds.
- R5: With mode m in 1..4 and direction 0, each `op_done_i` increments the low m bits of the pointer modulo 2^m. The upper pointer bits are left unchanged.
- R6: With mode m in 1..4 and direction 1, each `op_done_i` decrements the low m bits of the pointer modulo 2^m. The upper pointer bits are left unchanged.
- R7: A step is visible on `acc_sel_o` after the clock edge that samples `op_done_i` high. With `op_done_i` held high, the pointer steps on every cycle. With no write and no `op_done_i`, the pointer holds.
- R8: If an enabled step and a pointer write occur in the same cycle, the step is applied and the write data is discarded.
- R9: Writing 1 to control bit 7 clears the pointer to 0 on the next edge. This overrides any step in that cycle. The bit is never stored.
- R10: A control write that coincides with `op_done_i` takes effect for later operations. The step in that same cycle uses the previously stored mode and direction.
- R11: A pointer write in a cycle with no enabled step loads the pointer, even when `op_done_i` is high in a disabled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 1 | Register select: 0 pointer, 1 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| op_done_i | input | 1 | ALU operation completed this cycle |
| acc_sel_o | output | 4 | Current accumulator index |

## Verification
The bench builds the unit with its defaults: a 4-bit pointer and a 3-bit mode field. With these values every mode code, both directions and all sixteen starting pointers can be swept in full. This covers every wrap boundary of each window size, and the four unused mode codes. The same small state space makes the collision cases enumerable for every mode: step against pointer write, clear against step, and control rewrite against step. Each case is checked against an arithmetic model in the bench.

// File: rtl/acc_ptr_pkg.sv
package acc_ptr_pkg;
  localparam int REG_W   = 8;
  localparam int CLR_BIT = 7;
  localparam int DIR_BIT = 6;
  localparam logic SEL_PTR  = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/acc_ptr_step.sv
module acc_ptr_step #(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dir_i,
  output logic              step_en_o,
  output logic [PTR_W-1:0]  ptr_next_o
);
  logic [PTR_W-1:0] win_mask;
  logic [PTR_W-1:0] moved;

  // window of 2^mode entries: low mode bits move, rest held
  for (genvar i = 0; i < PTR_W; i++) begin : g_mask
    assign win_mask[i] = (i < int'(mode_i));
  end

  assign step_en_o  = (mode_i != '0) && (int'(mode_i) <= PTR_W);
  assign moved      = dir_i ? ptr_i - 1'b1 : ptr_i + 1'b1;
  assign ptr_next_o = (ptr_i & ~win_mask) | (moved & win_mask);
endmodule

// File: rtl/acc_ptr_regs.sv
module acc_ptr_regs
  import acc_ptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              op_done_i,
  input  logic              step_en_i,
  input  logic [PTR_W-1:0]  ptr_next_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              dir_o,
  output logic [MODE_W-1:0] mode_o
);
  logic ptr_wr, ctrl_wr, clr_req;
  logic unused_bits;

  assign ptr_wr  = wr_en_i && (addr_i == SEL_PTR);
  assign ctrl_wr = wr_en_i && (addr_i == SEL_CTRL);
  assign clr_req = ctrl_wr && wdata_i[CLR_BIT];
  assign unused_bits = ^wdata_i[5:3];

  // priority: clear > auto step > direct write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      dir_o  <= 1'b0;
      mode_o <= '0;
    end else begin
      if (clr_req)                      ptr_o <= '0;
      else if (op_done_i && step_en_i)  ptr_o <= ptr_next_i;
      else if (ptr_wr)                  ptr_o <= wdata_i[PTR_W-1:0];
      if (ctrl_wr) begin
        dir_o  <= wdata_i[DIR_BIT];
        mode_o <= wdata_i[MODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/acc_ptr_rdmux.sv
module acc_ptr_rdmux
  import acc_ptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic              addr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              dir_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [REG_W-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == SEL_PTR) begin
      rdata_o[PTR_W-1:0] = ptr_i;
    end else begin
      rdata_o[DIR_BIT]    = dir_i;
      rdata_o[MODE_W-1:0] = mode_i;
    end
  end
endmodule

// File: rtl/acc_ptr_unit.sv
module acc_ptr_unit
  import acc_ptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             op_done_i,
  output logic [PTR_W-1:0] acc_sel_o
);
  logic [PTR_W-1:0]  ptr_q, ptr_next;
  logic              dir_q, step_en;
  logic [MODE_W-1:0] mode_q;

  acc_ptr_step #(.PTR_W(PTR_W), .MODE_W(MODE_W)) u_step (
    .ptr_i      (ptr_q),
    .mode_i     (mode_q),
    .dir_i      (dir_q),
    .step_en_o  (step_en),
    .ptr_next_o (ptr_next)
  );

  acc_ptr_regs #(.PTR_W(PTR_W), .MODE_W(MODE_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .op_done_i  (op_done_i),
    .step_en_i  (step_en),
    .ptr_next_i (ptr_next),
    .ptr_o      (ptr_q),
    .dir_o      (dir_q),
    .mode_o     (mode_q)
  );

  acc_ptr_rdmux #(.PTR_W(PTR_W), .MODE_W(MODE_W)) u_rd (
    .addr_i  (addr_i),
    .ptr_i   (ptr_q),
    .dir_i   (dir_q),
    .mode_i  (mode_q),
    .rdata_o (rdata_o)
  );

  assign acc_sel_o = ptr_q;
endmodule

// File: rtl/acc_ptr_unit_chk.sv
module acc_ptr_unit_chk
  import acc_ptr_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int MODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              op_done_i,
  input logic [PTR_W-1:0]  acc_sel_o,
  input logic              dir_q,
  input logic [MODE_W-1:0] mode_q
);
  logic             mode_ok, clr_wr;
  logic [PTR_W-1:0] mask, step_val;

  assign mode_ok  = (mode_q != '0) && (int'(mode_q) <= PTR_W);
  assign clr_wr   = wr_en_i && (addr_i == SEL_CTRL) && wdata_i[CLR_BIT];
  assign mask     = PTR_W'((1 << int'(mode_q)) - 1);
  assign step_val = dir_q ? '1 : PTR_W'(1);

  assert_ptr_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == SEL_PTR |-> rdata_o[REG_W-1:PTR_W] == '0 && rdata_o[PTR_W-1:0] == acc_sel_o);

  assert_ctrl_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == SEL_CTRL |-> rdata_o[CLR_BIT] == 1'b0 && rdata_o[5:3] == 3'b000);

  assert_off_mode_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i && !wr_en_i && !mode_ok |=> $stable(acc_sel_o));

  assert_step_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i && mode_ok && !clr_wr |=>
      ((acc_sel_o ^ $past(acc_sel_o)) & ~$past(mask)) == '0 &&
      ((acc_sel_o - $past(acc_sel_o)) & $past(mask)) == ($past(step_val) & $past(mask)));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_done_i && !wr_en_i |=> $stable(acc_sel_o));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> acc_sel_o == '0);
endmodule

bind acc_ptr_unit acc_ptr_unit_chk #(.PTR_W(PTR_W), .MODE_W(MODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .op_done_i (op_done_i),
  .acc_sel_o (acc_sel_o),
  .dir_q     (dir_q),
  .mode_q    (mode_q)
);

// File: tb/acc_ptr_unit_tb.sv
module acc_ptr_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       op_done_i = 1'b0;
  logic [3:0] acc_sel_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [3:0] m_ptr = '0;
  logic [2:0] m_mode = '0;
  logic       m_dir = 1'b0;

  always #10 clk_i = ~clk_i;

  acc_ptr_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .op_done_i(op_done_i), .acc_sel_o(acc_sel_o)
  );

  function automatic logic [3:0] step_of(logic [3:0] p, logic [2:0] m, logic d);
    int k;
    int mv;
    int msk;
    k = int'(m);
    if (k < 1 || k > 4) return p;
    msk = (1 << k) - 1;
    mv  = d ? (int'(p) + 15) % 16 : (int'(p) + 1) % 16;
    return 4'((int'(p) & ~msk) | (mv & msk));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(logic we, logic a, logic [7:0] d, logic op, string req);
    logic old_ok;
    wr_en_i = we; addr_i = a; wdata_i = d; op_done_i = op;
    @(negedge clk_i);
    wr_en_i = 1'b0; op_done_i = 1'b0;
    old_ok = (m_mode >= 3'd1 && m_mode <= 3'd4);
    if (we && a && d[7]) m_ptr = '0;
    else if (op && old_ok) m_ptr = step_of(m_ptr, m_mode, m_dir);
    else if (we && !a) m_ptr = d[3:0];
    if (we && a) begin m_mode = d[2:0]; m_dir = d[6]; end
    chk(req, {4'h0, acc_sel_o}, {4'h0, m_ptr});
  endtask

  task automatic chk_reads(string req);
    addr_i = 1'b0; #1;
    chk(req, rdata_o, {4'h0, m_ptr});
    addr_i = 1'b1; #1;
    chk(req, rdata_o, {1'b0, m_dir, 3'b000, m_mode});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R3 reset ptr", {4'h0, acc_sel_o}, 8'h00);
    chk_reads("R3");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1/R2/R4/R5/R6/R7: full sweep of mode, direction and start pointer
    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 16; p++) begin
          cyc(1'b1, 1'b0, {4'hA, 4'(p)}, 1'b0, "R1 ptr write");
          cyc(1'b1, 1'b1, {1'b0, 1'(d), 3'b101, 3'(m)}, 1'b0, "R2 ctrl write");
          chk_reads("R1 R2 readback");
          cyc(1'b0, 1'b0, 8'h00, 1'b1, d ? "R6 decrement" : "R5 increment");
          cyc(1'b0, 1'b0, 8'h00, 1'b1, "R4 R7 second op");
          cyc(1'b0, 1'b0, 8'h00, 1'b0, "R7 idle hold");
        end

    // R8/R11: pointer write colliding with op_done in every mode
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 16; p++) begin
        cyc(1'b1, 1'b1, {1'b0, 1'(p & 1), 3'b000, 3'(m)}, 1'b0, "R2 ctrl setup");
        cyc(1'b1, 1'b0, {4'h0, 4'(p)}, 1'b0, "R11 ptr write");
        cyc(1'b1, 1'b0, {4'h5, ~4'(p)}, 1'b1, (m >= 1 && m <= 4) ? "R8 step wins" : "R11 write in off mode");
      end

    // R9: clear against step, and clear while idle
    for (int m = 0; m < 8; m++) begin
      cyc(1'b1, 1'b0, 8'h0B, 1'b0, "R1 ptr write");
      cyc(1'b1, 1'b1, {1'b1, 1'b1, 3'b000, 3'(m)}, 1'b1, "R9 clear over step");
      chk_reads("R9 clear bit reads 0");
      cyc(1'b1, 1'b0, 8'h07, 1'b0, "R1 ptr write");
      cyc(1'b1, 1'b1, {1'b1, 1'b0, 3'b000, 3'(m)}, 1'b0, "R9 clear idle");
    end

    // R10: control rewrite coincident with op_done uses old setting
    for (int m = 0; m < 8; m++)
      for (int n = 0; n < 8; n++) begin
        cyc(1'b1, 1'b1, {1'b0, 1'b1, 3'b000, 3'(m)}, 1'b0, "R2 ctrl setup");
        cyc(1'b1, 1'b0, 8'h09, 1'b0, "R1 ptr write");
        cyc(1'b1, 1'b1, {1'b0, 1'b0, 3'b000, 3'(n)}, 1'b1, "R10 old mode step");
        cyc(1'b0, 1'b0, 8'h00, 1'b1, "R10 new mode step");
      end

    // R7: op_done held high for consecutive cycles
    cyc(1'b1, 1'b1, 8'h43, 1'b0, "R2 ctrl setup");
    cyc(1'b1, 1'b0, 8'h0C, 1'b0, "R1 ptr write");
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, "R7 back-to-back");

    // R3: asynchronous reset mid-run
    cyc(1'b1, 1'b1, 8'h44, 1'b0, "R2 ctrl setup");
    cyc(1'b1, 1'b0, 8'h0E, 1'b0, "R1 ptr write");
    #3 rst_ni = 1'b0; #1;
    m_ptr = '0; m_mode = '0; m_dir = 1'b0;
    chk("R3 async reset ptr", {4'h0, acc_sel_o}, 8'h00);
    chk_reads("R3 async reset regs");
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(1'b0, 1'b0, 8'h00, 1'b1, "R3 R4 off after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule